// File: doc/BRIEF.md
# Counter and PWM Timer Channel

This block is one timer channel with a small register interface. Software programs a target, an idle pin level, a pin action and a mode, then sets the run bit. In counter mode the channel counts ticks up to the target and then acts on its output pin. It either stops there or restarts, depending on the repeat bit. In PWM mode the target register holds two 16-bit phase lengths, and the pin alternates between the idle level (phase 0) and its inverse (phase 1) without stopping.

Ticks come from one of two sources, chosen by a control bit. The internal source is the system clock divided by the parameter `DIV`. The external source is a synchronised input pin, and each rising edge on it is one tick. Each completed count, and each PWM level change, is an event. An event sets a pending flag when interrupts are enabled. An event that arrives while the flag is still pending also sets an overflow flag. A read of the count register clears both flags.

The controller has four states. `ST_IDLE` is stopped. `ST_COUNT` is counting. `ST_HOLD` is a finished single run. `ST_PWM` is PWM running. The transitions are:
- `ST_IDLE` to `ST_COUNT` when run is set with mode 0.
- `ST_IDLE` to `ST_PWM` when run is set with mode 1.
- `ST_COUNT` to `ST_HOLD` when a count completes with repeat off.
- Any state to `ST_IDLE` when run is cleared.

With mode codes 2 or 3 the channel stays in `ST_IDLE`.

Top module: `timer_channel`

Register map (`addr`):
- 0: control. Bit 0 run, bits 2:1 mode, bits 4:3 pin action, bit 5 repeat, bit 6 external source.
- 1: target.
- 2: idle level (bit 0).
- 3: interrupt config. Bit 0 enable, bit 1 mask (1 = masked).
- 4: count. Reading it clears the flags.
- 5: status. Bit 0 pending, bit 1 pending and not masked, bit 2 overflow, bit 3 PWM phase.

## Requirements
- R1: After reset, `pin_out` and `irq_out` are 0 and count and status read 0. While run is 0, the count reads 0 and `pin_out` follows the idle-level register one cycle later.
- R2: In counter mode with the internal source, a target of T completes after T ticks, one tick every `DIV` clocks. The event is visible `DIV*T+1` cycles after the edge that writes run=1.
- R3: On completion the pin takes the action selected by control bits 4:3. Code 0 leaves it alone, 1 toggles it, 2 drives it to 1 and 3 drives it to 0.
- R4: With repeat=1 the count restarts from 0 after each completion. With repeat=0 the count stays at the target and no further events occur. PWM mode repeats whatever the repeat bit says.
- R5: In PWM mode, target bits 15:0 give the phase 0 length and bits 31:16 give the phase 1 length, in ticks. The pin is the idle level in phase 0 and its inverse in phase 1. Status bit 3 shows the current phase.
- R6: Every PWM level change is an event.
- R7: An event sets pending (status bit 0) only when interrupt enable is 1. The mask forces `irq_out` and status bit 1 to 0 while pending stays set. Clearing the mask raises `irq_out` at once.
- R8: An event that arrives while pending is already set sets overflow (status bit 2).
- R9: A read of the count register clears pending and overflow at that clock edge.
- R10: A target of 0, or a phase length of 0, counts as 1 tick.
- R11: With the external source selected, each rising edge of `ext_tick_in` is one tick, after a two-flop synchroniser. The internal source is then ignored.
- R12: Mode codes 2 and 3 do not count and raise no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the read-clear) |
| addr | input | 3 | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data, combinational from `addr` |
| ext_tick_in | input | 1 | External tick source (asynchronous) |
| pin_out | output | 1 | Timer output pin |
| irq_out | output | 1 | Interrupt request (pending and not masked) |

## Verification
A wrong state or a miscounted prescaler shows as an event that arrives early or late. The bench therefore measures the exact cycle of the first interrupt against `DIV*T+1`, so an off-by-one appears within one tick. A stuck phase or wrong phase length in PWM shows on `pin_out` in the very cycle the level should change, because the bench compares the pin every clock against a computed waveform. A pending or overflow flag that is not cleared, or is set wrongly, shows on the next read of status.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TARGET = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IRQCFG = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

    localparam logic [1:0] MODE_COUNT = 2'd0;
    localparam logic [1:0] MODE_PWM   = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_HOLD,
        ST_PWM
    } tmr_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_HIGH,
        ACT_LOW
    } pin_act_e;

    typedef struct packed {
        logic     ext_src;
        logic     repeat_en;
        pin_act_e act;
        logic [1:0] mode;
        logic     run;
    } ctrl_t;
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic use_ext,
    input  logic ext_in,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;
    logic s1_q, s2_q, s3_q;
    logic int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            s3_q  <= 1'b0;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (!active || use_ext || pre_q == PW'(DIV-1))
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end
    end

    assign int_tick = active && (pre_q == PW'(DIV-1));
    assign tick     = use_ext ? (active && s2_q && !s3_q) : int_tick;

    // R11
    ext_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && tick) |=> !tick);

    // R2
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tick);
endmodule

// File: rtl/timer_fsm.sv
module timer_fsm
    import timer_pkg::*;
#(
    parameter int CW  = 32,
    parameter int PHW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    mode,
    input  pin_act_e      act,
    input  logic          repeat_en,
    input  logic          init_lvl,
    input  logic [CW-1:0] target,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          pin,
    output logic          phase,
    output logic          evt,
    output logic          active
);
    tmr_state_e state_q, state_d;
    logic [CW-1:0]  count_q, count_nxt, target_eff, phase_len;
    logic [PHW-1:0] len0, len1;
    logic           pin_q, phase_q, pin_act_val;
    logic           cnt_done, pwm_done;

    assign target_eff = (target == '0) ? CW'(1) : target;
    assign len0       = (target[PHW-1:0] == '0) ? PHW'(1) : target[PHW-1:0];
    assign len1       = (target[2*PHW-1:PHW] == '0) ? PHW'(1) : target[2*PHW-1:PHW];
    assign phase_len  = phase_q ? CW'(len1) : CW'(len0);
    assign count_nxt  = count_q + 1'b1;

    assign cnt_done = (state_q == ST_COUNT) && run && tick && (count_nxt >= target_eff);
    assign pwm_done = (state_q == ST_PWM)   && run && tick && (count_nxt >= phase_len);
    assign evt      = cnt_done || pwm_done;
    assign active   = (state_q == ST_COUNT) || (state_q == ST_PWM);

    always_comb begin
        unique case (act)
            ACT_NONE:   pin_act_val = pin_q;
            ACT_TOGGLE: pin_act_val = !pin_q;
            ACT_HIGH:   pin_act_val = 1'b1;
            ACT_LOW:    pin_act_val = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run && mode == MODE_COUNT)    state_d = ST_COUNT;
                else if (run && mode == MODE_PWM) state_d = ST_PWM;
            end
            ST_COUNT: begin
                if (!run)                        state_d = ST_IDLE;
                else if (cnt_done && !repeat_en) state_d = ST_HOLD;
            end
            ST_HOLD:  if (!run) state_d = ST_IDLE;
            ST_PWM:   if (!run) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pin_q   <= 1'b0;
            phase_q <= 1'b0;
        end else if (!run || state_q == ST_IDLE) begin
            count_q <= '0;
            pin_q   <= init_lvl;
            phase_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_COUNT: begin
                    if (cnt_done) begin
                        count_q <= repeat_en ? '0 : count_nxt;
                        pin_q   <= pin_act_val;
                    end else if (tick) begin
                        count_q <= count_nxt;
                    end
                end
                ST_HOLD: ;
                ST_PWM: begin
                    if (pwm_done) begin
                        count_q <= '0;
                        phase_q <= !phase_q;
                        pin_q   <= !pin_q;
                    end else if (tick) begin
                        count_q <= count_nxt;
                    end
                end
            endcase
        end
    end

    assign count = count_q;
    assign pin   = pin_q;
    assign phase = phase_q;

    // R1
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_q == '0));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && run) |=> $stable(count_q));

    // R6
    phase_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWM && run && !tick) |=> $stable(phase_q));

    // R12
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && run && mode[1]) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic irq_en,
    input  logic mask,
    input  logic clr,
    output logic pend,
    output logic ovf,
    output logic irq
);
    logic pend_q, ovf_q, hit;

    assign hit = evt && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q && !clr) || hit;
            ovf_q  <= (ovf_q && !clr) || (hit && pend_q && !clr);
        end
    end

    assign pend = pend_q;
    assign ovf  = ovf_q;
    assign irq  = pend_q && !mask;

    // R8
    ovf_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(pend_q));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!pend_q && !ovf_q));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !pend_q) |=> !pend_q);
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int CW  = 32,
    parameter int PHW = 16,
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic              ext_tick_in,
    output logic              pin_out,
    output logic              irq_out
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl_q;
    logic [CW-1:0] target_q, count;
    logic          level_q, irq_en_q, mask_q;
    logic          tick, active, evt, phase, pend, ovf, clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            target_q <= '0;
            level_q  <= 1'b0;
            irq_en_q <= 1'b0;
            mask_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_TARGET: target_q <= wdata;
                A_LEVEL:  level_q  <= wdata[0];
                A_IRQCFG: begin
                    irq_en_q <= wdata[0];
                    mask_q   <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    assign clr = rd_en && (addr == A_COUNT);

    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = CW'(ctrl_q);
            A_TARGET: rdata = target_q;
            A_LEVEL:  rdata = CW'(level_q);
            A_IRQCFG: rdata = CW'({mask_q, irq_en_q});
            A_COUNT:  rdata = count;
            A_STATUS: rdata = CW'({phase, ovf, irq_out, pend});
            default:  rdata = '0;
        endcase
    end

    timer_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .use_ext (ctrl_q.ext_src),
        .ext_in  (ext_tick_in),
        .tick    (tick)
    );

    timer_fsm #(.CW(CW), .PHW(PHW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run),
        .mode      (ctrl_q.mode),
        .act       (ctrl_q.act),
        .repeat_en (ctrl_q.repeat_en),
        .init_lvl  (level_q),
        .target    (target_q),
        .tick      (tick),
        .count     (count),
        .pin       (pin_out),
        .phase     (phase),
        .evt       (evt),
        .active    (active)
    );

    timer_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .irq_en (irq_en_q),
        .mask   (mask_q),
        .clr    (clr),
        .pend   (pend),
        .ovf    (ovf),
        .irq    (irq_out)
    );

    // R7
    mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && $past(mask_q)) |-> !irq_out);
endmodule

// File: tb/tb_timer_channel.sv
module tb_timer_channel;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        ext_tick_in = 1'b0;
    logic        pin_out, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_channel #(.CW(32), .PHW(16), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_tick_in(ext_tick_in),
        .pin_out(pin_out), .irq_out(irq_out)
    );

    function automatic logic [31:0] ctrl_word(input bit run, input int mode, input int act,
                                              input bit rep, input bit ext);
        return 32'(run) | (32'(mode) << 1) | (32'(act) << 3) | (32'(rep) << 5) | (32'(ext) << 6);
    endfunction

    function automatic bit pwm_phase(input int n, input int l0, input int l1);
        int e, r;
        e = (n - 1) / DIV;
        r = e % (l0 + l1);
        return (r >= l0);
    endfunction

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_irq(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(posedge clk); n++; @(negedge clk);
            if (irq_out) break;
        end
    endtask

    task automatic stop_and_clear();
        logic [31:0] d;
        wr(3'd0, 32'd0);
        rd(3'd4, d);
    endtask

    task automatic ext_pulse();
        ext_tick_in = 1'b1; cycles(3);
        ext_tick_in = 1'b0; cycles(3);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 pin after reset", pin_out, 0);
        check_eq("R1 irq after reset", irq_out, 0);
        rd(3'd4, d); check_eq("R1 count after reset", d, 0);
        rd(3'd5, d); check_eq("R1 status after reset", d, 0);

        // R2 R3 R4 single count with toggle
        wr(3'd3, 32'd1);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd5);
        wr(3'd0, ctrl_word(1, 0, 1, 0, 0));
        wait_irq(100, n);
        check_eq("R2 single count latency", n, DIV*5+1);
        check_eq("R3 toggle action", pin_out, 1);
        cycles(30);
        rd(3'd4, d); check_eq("R4 single run holds count at target", d, 5);
        cycles(30);
        check_eq("R4 no further event in single run", irq_out, 0);
        rd(3'd5, d); check_eq("R4 pending stays clear", d[0], 0);
        wr(3'd0, 32'd0);
        cycles(2);
        check_eq("R1 pin back to idle level", pin_out, 0);
        rd(3'd4, d); check_eq("R1 count cleared when stopped", d, 0);

        // R10 target zero, R3 drive high
        wr(3'd1, 32'd0);
        wr(3'd0, ctrl_word(1, 0, 2, 0, 0));
        wait_irq(100, n);
        check_eq("R10 zero target as one tick", n, DIV+1);
        check_eq("R3 drive-high action", pin_out, 1);
        stop_and_clear();

        // R3 drive low with idle level 1
        wr(3'd2, 32'd1);
        cycles(1);
        check_eq("R1 pin follows idle level", pin_out, 1);
        wr(3'd1, 32'd3);
        wr(3'd0, ctrl_word(1, 0, 3, 0, 0));
        wait_irq(100, n);
        check_eq("R2 latency target 3", n, DIV*3+1);
        check_eq("R3 drive-low action", pin_out, 0);
        stop_and_clear();

        // R4 R8 R9 repeating count with toggle
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd4);
        wr(3'd0, ctrl_word(1, 0, 1, 1, 0));
        wait_irq(100, n);
        check_eq("R2 repeat first latency", n, DIV*4+1);
        check_eq("R3 toggle first", pin_out, 1);
        rd(3'd5, d); check_eq("R8 no overflow after one event", d[2], 0);
        cycles(DIV*4 - 1);
        check_eq("R4 repeat toggles again", pin_out, 0);
        rd(3'd5, d); check_eq("R8 overflow on second event", d[2], 1);
        rd(3'd4, d);
        rd(3'd5, d);
        check_eq("R9 read clears pending", d[0], 0);
        check_eq("R9 read clears overflow", d[2], 0);
        stop_and_clear();

        // R7 mask and enable
        wr(3'd3, 32'd3);
        wr(3'd1, 32'd2);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0));
        cycles(DIV*2 + 3);
        check_eq("R7 masked irq low", irq_out, 0);
        rd(3'd5, d);
        check_eq("R7 raw pending set under mask", d[0], 1);
        check_eq("R7 masked status bit low", d[1], 0);
        wr(3'd3, 32'd1);
        check_eq("R7 unmask raises irq", irq_out, 1);
        stop_and_clear();
        wr(3'd3, 32'd0);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0));
        cycles(10);
        rd(3'd5, d); check_eq("R7 disabled interrupt no pending", d[0], 0);
        stop_and_clear();
        wr(3'd3, 32'd1);

        // R5 R6 PWM, repeat bit 0 still repeats (R4)
        wr(3'd2, 32'd1);
        wr(3'd1, (32'd3 << 16) | 32'd2);
        wr(3'd0, ctrl_word(1, 1, 0, 0, 0));
        for (int i = 1; i <= 60; i++) begin
            @(posedge clk); @(negedge clk);
            check_eq("R5 pwm pin waveform", pin_out, 1 ^ pwm_phase(i, 2, 3));
        end
        rd(3'd5, d);
        check_eq("R5 phase status bit", d[3], pwm_phase(60, 2, 3));
        check_eq("R6 pwm level change raised event", d[0], 1);
        check_eq("R6 R8 repeated pwm events overflow", d[2], 1);
        stop_and_clear();

        // R10 zero phase lengths
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd0, ctrl_word(1, 1, 0, 0, 0));
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk); @(negedge clk);
            check_eq("R10 zero phase as one tick", pin_out, pwm_phase(i, 1, 1));
        end
        stop_and_clear();

        // R12 reserved mode
        wr(3'd1, 32'd1);
        wr(3'd0, ctrl_word(1, 2, 1, 1, 0));
        cycles(20);
        check_eq("R12 reserved mode no event", irq_out, 0);
        rd(3'd4, d); check_eq("R12 reserved mode no count", d, 0);
        check_eq("R12 reserved mode pin unchanged", pin_out, 0);
        stop_and_clear();

        // R11 external tick source
        wr(3'd1, 32'd3);
        wr(3'd0, ctrl_word(1, 0, 1, 0, 1));
        cycles(40);
        check_eq("R11 internal ticks ignored", irq_out, 0);
        ext_pulse(); ext_pulse();
        check_eq("R11 two edges not enough", irq_out, 0);
        rd(3'd4, d); check_eq("R11 count after two edges", d, 2);
        ext_pulse();
        check_eq("R11 third edge completes", irq_out, 1);
        check_eq("R11 toggle on external completion", pin_out, 1);
        stop_and_clear();

        // R2 R4 random targets
        wr(3'd2, 32'd0);
        for (int k = 0; k < 10; k++) begin
            int t;
            bit rep;
            t   = $urandom_range(1, 9);
            rep = 1'($urandom_range(0, 1));
            wr(3'd1, 32'(t));
            wr(3'd0, ctrl_word(1, 0, 1, rep, 0));
            wait_irq(200, n);
            check_eq("R2 random first latency", n, DIV*t+1);
            rd(3'd4, d);
            if (rep) begin
                check_eq("R4 repeat count restarted", d, 0);
                wait_irq(200, n);
                check_eq("R4 repeat second latency", n, DIV*t-1);
            end else begin
                check_eq("R4 single count value", d, t);
                cycles(DIV*t + 4);
                check_eq("R4 single no second event", irq_out, 0);
            end
            stop_and_clear();
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule